// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block moves a chosen subset of sixteen 32-bit registers, eight data registers and eight address registers, between a register file and a run of consecutive memory locations. A 16-bit select mask names the registers that take part; the sequencer visits the selected ones in a fixed order, issues exactly one memory access per selected register, and skips unselected registers without spending a cycle on them. Each transfer is either a 16-bit word or a 32-bit longword.

Two addressing forms change the walk. A store in predecrement form reverses the meaning of the mask, lowers the address by the transfer size before each write, and returns the lowest address written to the base address register. A load in postincrement form walks in the normal ascending order and returns the address just past the last item read to the base address register. When the walk ends the block pulses a done flag and presents an execution-cost figure. The figure is built from a charge per transferred register plus a charge that depends on the addressing form.

The block is started with a one-cycle start strobe carrying direction, size, addressing mode, mode subfield, mask and start address. It drives a request/ready memory port and a register-file port with one combinational read and one write per cycle.

Top module: `mrx_seq`

## Requirements
- R1: In ascending order, mask bit k selects register index k, where indices 0..7 are the data registers and 8..15 are the address registers 0..7. Selected registers are transferred lowest bit first, one access each, with the first access at the start address and each later address raised by the transfer size.
- R2: `size_long`=0 selects word transfers with an address step of 2; `size_long`=1 selects longword transfers with a step of 4. `mem_size_long` reports the size of every access.
- R3: A store (`dir_store`=1) with `ea_mode`=4 uses predecrement form. Mask bit k selects register index 15-k, lowest bit first. Each access address is the previous address minus the size, and the first access is at start address minus the size.
- R4: After a predecrement store, the register file receives a write of the final (lowest) address to index 8+`ea_sub`, on the cycle after the last access completes.
- R5: After a load (`dir_store`=0) with `ea_mode`=3, the register file receives a write of the start address plus count times size to index 8+`ea_sub`, on the cycle after the last access completes. No other combination writes back an address.
- R6: A word load writes the 16 read bits sign-extended to 32 bits. A longword load writes all 32 bits. A word store drives the low 16 register bits on `mem_wdata[15:0]`, with the upper half zero.
- R7: For loads, `cycle_total` equals the count of transferred registers times 4 (word) or 8 (longword), plus a mode charge. The mode charges are: 2→12, 3→12, 5→16, 6→18, and for mode 7 by subfield 0→16, 1→20, 2→16, 3→18.
- R8: For stores, the mode charge is 2→8, 4→8, 5→12, 6→14, and for mode 7 by subfield 0→12, 1→16. Any mode or subfield not listed for the direction adds 0.
- R9: An all-zero mask makes no memory request, still pulses done, and reports only the mode charge. A writeback that applies (R4, R5) still writes the unchanged start address.
- R10: A request holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ready` is sampled high. A load writes the register file in the same cycle that `mem_ready` is high.
- R11: `done` is a one-cycle pulse, and `cycle_total` is valid while `done` is high. `busy` is high from the cycle after start until the done cycle, and it is low again on the following cycle. A start that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer; sampled only when idle |
| dir_store | input | 1 | 1 = registers to memory, 0 = memory to registers |
| size_long | input | 1 | 1 = longword, 0 = word |
| ea_mode | input | 3 | Addressing mode field |
| ea_sub | input | 3 | Mode subfield / base address register number |
| reg_mask | input | 16 | Register select mask |
| base_addr | input | AW | Start address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_size_long | output | 1 | Size of the current access |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes on this cycle |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cycle_total | output | CW | Cost figure, valid with done |

## Verification
After the start edge, the first request is visible in the next cycle, and a load's register write appears in the very cycle that ready is high. The writeback, if any, follows one cycle after the last completed access, and done with its cost figure comes one cycle after that, or directly after start for an empty mask with no writeback. The bench model holds a queue of expected accesses and a flag for the pending writeback, and it checks every clock at the falling edge against whichever of these is due. Ready is driven either every cycle or one cycle in three, so held requests and back-to-back accesses are both covered.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    localparam int NREG   = 16;
    localparam int RIW    = $clog2(NREG);
    localparam int DW     = 32;
    localparam int HALF_W = DW / 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_WBACK,
        ST_DONE
    } mrx_state_e;

    typedef struct packed {
        logic       store;
        logic       long_sz;
        logic [2:0] mode;
        logic [2:0] sub;
    } mrx_cmd_t;

    function automatic logic [7:0] mode_charge(logic store, logic [2:0] mode, logic [2:0] sub);
        logic [7:0] c;
        c = 8'd0;
        if (store) begin
            case (mode)
                3'd2, 3'd4: c = 8'd8;
                3'd5:       c = 8'd12;
                3'd6:       c = 8'd14;
                3'd7: begin
                    if (sub == 3'd0)      c = 8'd12;
                    else if (sub == 3'd1) c = 8'd16;
                end
                default:    c = 8'd0;
            endcase
        end else begin
            case (mode)
                3'd2, 3'd3: c = 8'd12;
                3'd5:       c = 8'd16;
                3'd6:       c = 8'd18;
                3'd7: begin
                    case (sub)
                        3'd0, 3'd2: c = 8'd16;
                        3'd1:       c = 8'd20;
                        3'd3:       c = 8'd18;
                        default:    c = 8'd0;
                    endcase
                end
                default:    c = 8'd0;
            endcase
        end
        return c;
    endfunction

    function automatic logic [DW-1:0] sext_half(logic [HALF_W-1:0] h);
        return {{(DW-HALF_W){h[HALF_W-1]}}, h};
    endfunction

endpackage

// File: rtl/mrx_pick.sv
module mrx_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          last
);
    logic [N-1:0] below_clear;

    // below_clear[i] = no lower bit of vec is set
    assign below_clear[0] = 1'b1;
    for (genvar g = 1; g < N; g++) begin : g_chain
        assign below_clear[g] = below_clear[g-1] & ~vec[g-1];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i] && below_clear[i]) idx = IW'(i);
        end
    end

    assign last = ((vec & (vec - N'(1))) == '0);
endmodule

// File: rtl/mrx_cost.sv
module mrx_cost #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic [CW-1:0] init_val,
    input  logic          add,
    input  logic [CW-1:0] add_val,
    output logic [CW-1:0] total
);
    always_ff @(posedge clk) begin
        if (rst)       total <= '0;
        else if (init) total <= init_val;
        else if (add)  total <= total + add_val;
    end
endmodule

// File: rtl/mrx_seq.sv
module mrx_seq
    import mrx_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            dir_store,
    input  logic            size_long,
    input  logic [2:0]      ea_mode,
    input  logic [2:0]      ea_sub,
    input  logic [NREG-1:0] reg_mask,
    input  logic [AW-1:0]   base_addr,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_size_long,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ready,
    output logic [RIW-1:0]  rf_raddr,
    input  logic [DW-1:0]   rf_rdata,
    output logic            rf_we,
    output logic [RIW-1:0]  rf_waddr,
    output logic [DW-1:0]   rf_wdata,
    output logic            busy,
    output logic            done,
    output logic [CW-1:0]   cycle_total
);
    localparam logic [AW-1:0] STEP_W = AW'(2);
    localparam logic [AW-1:0] STEP_L = AW'(4);
    localparam logic [CW-1:0] COST_W = CW'(4);
    localparam logic [CW-1:0] COST_L = CW'(8);

    mrx_state_e      state;
    mrx_cmd_t        cmd;
    logic [NREG-1:0] pend;
    logic [AW-1:0]   addr;
    logic            predec;
    logic            wb_need;

    logic [RIW-1:0]  sel_bit;
    logic            sel_last;
    logic [RIW-1:0]  sel_reg;
    logic [AW-1:0]   step;
    logic            fire;
    logic            go;
    logic            go_predec;
    logic            go_wb;
    logic [CW-1:0]   go_charge;

    mrx_pick #(.N(NREG), .IW(RIW)) u_pick (
        .vec  (pend),
        .idx  (sel_bit),
        .last (sel_last)
    );

    assign go        = start && (state == ST_IDLE);
    assign go_predec = dir_store && (ea_mode == 3'd4);
    assign go_wb     = go_predec || (!dir_store && (ea_mode == 3'd3));
    assign go_charge = CW'(mode_charge(dir_store, ea_mode, ea_sub));

    assign step    = cmd.long_sz ? STEP_L : STEP_W;
    assign sel_reg = predec ? RIW'(NREG - 1 - int'(sel_bit)) : sel_bit;
    assign fire    = mem_req && mem_ready;

    mrx_cost #(.CW(CW)) u_cost (
        .clk      (clk),
        .rst      (rst),
        .init     (go),
        .init_val (go_charge),
        .add      (fire),
        .add_val  (cmd.long_sz ? COST_L : COST_W),
        .total    (cycle_total)
    );

    // sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cmd     <= '0;
            pend    <= '0;
            addr    <= '0;
            predec  <= 1'b0;
            wb_need <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cmd     <= '{store: dir_store, long_sz: size_long,
                                     mode: ea_mode, sub: ea_sub};
                        pend    <= reg_mask;
                        addr    <= base_addr;
                        predec  <= go_predec;
                        wb_need <= go_wb;
                        if (reg_mask != '0) state <= ST_XFER;
                        else if (go_wb)     state <= ST_WBACK;
                        else                state <= ST_DONE;
                    end
                end
                ST_XFER: begin
                    if (mem_ready) begin
                        addr          <= predec ? addr - step : addr + step;
                        pend[sel_bit] <= 1'b0;
                        if (sel_last) state <= wb_need ? ST_WBACK : ST_DONE;
                    end
                end
                ST_WBACK: state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // memory port
    assign mem_req       = (state == ST_XFER);
    assign mem_we        = cmd.store;
    assign mem_size_long = cmd.long_sz;
    assign mem_addr      = predec ? addr - step : addr;
    assign mem_wdata     = cmd.long_sz ? rf_rdata
                                       : {{(DW-HALF_W){1'b0}}, rf_rdata[HALF_W-1:0]};

    // register-file port
    assign rf_raddr = sel_reg;
    assign rf_we    = (fire && !cmd.store) || (state == ST_WBACK);
    assign rf_waddr = (state == ST_WBACK) ? {1'b1, cmd.sub} : sel_reg;
    assign rf_wdata = (state == ST_WBACK) ? DW'(addr)
                    : (cmd.long_sz ? mem_rdata : sext_half(mem_rdata[HALF_W-1:0]));

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);

    // ---------------- assertions ----------------
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_wdata)));

    assert_up_step_R1: assert property (@(posedge clk) disable iff (rst)
        (fire && !predec) |=> (!mem_req || (mem_addr == $past(mem_addr) + $past(step))));

    assert_down_step_R3: assert property (@(posedge clk) disable iff (rst)
        (fire && predec) |=> (!mem_req || (mem_addr == $past(mem_addr) - $past(step))));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    assert_empty_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (go && reg_mask == '0) |=> !mem_req);

    assert_store_no_rf_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !rf_we);

endmodule

// File: tb/mrx_seq_tb_top.sv
`timescale 1ns/1ps
module mrx_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dir_store = 1'b0;
    logic        size_long = 1'b0;
    logic [2:0]  ea_mode = 3'd0;
    logic [2:0]  ea_sub = 3'd0;
    logic [15:0] reg_mask = 16'd0;
    logic [31:0] base_addr = 32'd0;
    logic        mem_req, mem_we, mem_size_long;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we, busy, done;
    logic [15:0] cycle_total;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mrx_seq dut_i (.*);

    function automatic logic [31:0] init_val(int i);
        return (32'h1111_1111 * i) ^ 32'h0000_8000 ^ 32'h0300_0000;
    endfunction

    // bench register file
    logic [31:0] rf [16];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) rf[i] <= init_val(i);
        end else if (rf_we) begin
            rf[rf_waddr] <= rf_wdata;
        end
    end
    assign rf_rdata = rf[rf_raddr];

    // bench memory: read data is a fixed function of the address
    function automatic logic [31:0] mem_fn(logic [31:0] a);
        return {~a[15:0], a[15:0] ^ 16'h9C31};
    endfunction
    assign mem_rdata = mem_fn(mem_addr);

    logic [31:0] exp_regs [16];

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int mode_cost_ref(bit st, logic [2:0] md, logic [2:0] sb);
        if (st) begin
            if (md == 2 || md == 4) return 8;
            if (md == 5) return 12;
            if (md == 6) return 14;
            if (md == 7 && sb == 0) return 12;
            if (md == 7 && sb == 1) return 16;
            return 0;
        end
        if (md == 2 || md == 3) return 12;
        if (md == 5) return 16;
        if (md == 6) return 18;
        if (md == 7) begin
            if (sb == 0 || sb == 2) return 16;
            if (sb == 1) return 20;
            if (sb == 3) return 18;
        end
        return 0;
    endfunction

    task automatic run_op(bit st, bit lg, logic [2:0] md, logic [2:0] sb,
                          logic [15:0] mk, logic [31:0] base, bit slow);
        int          q_reg[$];
        logic [31:0] q_adr[$];
        logic [31:0] a, step, wba, ev;
        bit          pre, wb;
        int          n, cost, cyc, r;
        string       atag, wtag, ctag;
        bit          fin;
        step = lg ? 32'd4 : 32'd2;
        pre  = st && (md == 3'd4);
        wb   = pre || (!st && md == 3'd3);
        atag = pre ? "R3" : "R1";
        wtag = pre ? "R4" : "R5";
        ctag = (mk == 0) ? "R9" : (st ? "R8" : "R7");
        a = base; n = 0;
        for (int k = 0; k < 16; k++) begin
            if (mk[k]) begin
                if (pre) begin
                    a = a - step;
                    q_adr.push_back(a); q_reg.push_back(15 - k);
                end else begin
                    q_adr.push_back(a); q_reg.push_back(k);
                    a = a + step;
                end
                n++;
            end
        end
        wba  = a;
        cost = mode_cost_ref(st, md, sb) + n * (lg ? 8 : 4);

        @(negedge clk);
        dir_store = st; size_long = lg; ea_mode = md; ea_sub = sb;
        reg_mask = mk; base_addr = base; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        cyc = 0;
        mem_ready = slow ? 1'b0 : 1'b1;
        fin = 0;
        while (!fin) begin
            @(negedge clk);
            if (q_reg.size() > 0) begin
                r = q_reg[0];
                chk(mem_req === 1'b1 && done === 1'b0, "R10 request", {31'd0, mem_req}, 32'd1);
                chk(mem_addr === q_adr[0], atag, mem_addr, q_adr[0]);
                chk(mem_we === st, "R1 direction", {31'd0, mem_we}, {31'd0, st});
                chk(mem_size_long === lg, "R2 size", {31'd0, mem_size_long}, {31'd0, lg});
                if (st) begin
                    ev = lg ? exp_regs[r] : {16'd0, exp_regs[r][15:0]};
                    chk(mem_wdata === ev, "R6 store data", mem_wdata, ev);
                    chk(rf_we === 1'b0, "R6 store no rf write", {31'd0, rf_we}, 32'd0);
                end else if (mem_ready) begin
                    ev = mem_fn(q_adr[0]);
                    if (!lg) ev = {{16{ev[15]}}, ev[15:0]};
                    chk(rf_we === 1'b1 && rf_waddr === r[3:0], "R10 load write",
                        {27'd0, rf_we, rf_waddr}, {28'd1, r[3:0]});
                    chk(rf_wdata === ev, "R6 load data", rf_wdata, ev);
                    exp_regs[r] = ev;
                end else begin
                    chk(rf_we === 1'b0, "R10 no write before ready", {31'd0, rf_we}, 32'd0);
                end
                if (mem_ready) begin
                    void'(q_reg.pop_front());
                    void'(q_adr.pop_front());
                end
            end else if (wb) begin
                chk(rf_we === 1'b1 && rf_waddr === {1'b1, sb} && mem_req === 1'b0, wtag,
                    {27'd0, rf_we, rf_waddr}, {28'd1, 1'b1, sb});
                chk(rf_wdata === wba, wtag, rf_wdata, wba);
                exp_regs[{1'b1, sb}] = wba;
                wb = 0;
            end else begin
                chk(done === 1'b1 && mem_req === 1'b0 && busy === 1'b1, "R11 done",
                    {30'd0, done, mem_req}, 32'd2);
                chk(cycle_total === cost[15:0], ctag, {16'd0, cycle_total}, cost);
                fin = 1;
            end
            if (!fin) begin
                if (cyc > 200) begin
                    chk(1'b0, "R11 hang", 32'd0, 32'd1);
                    fin = 1;
                end
                @(posedge clk); #1;
                cyc++;
                mem_ready = slow ? ((cyc % 3) == 2) : 1'b1;
            end
        end
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R11 pulse end", {30'd0, done, busy}, 32'd0);
        mem_ready = 1'b0;
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            checks++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) exp_regs[i] = init_val(i);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0 && rf_we === 1'b0,
            "R11 reset state", {28'd0, busy, done, mem_req, rf_we}, 32'd0);

        // R1 R2 R7: ascending longword load, D0, A0, A7
        run_op(1'b0, 1'b1, 3'd2, 3'd0, 16'h8101, 32'h0000_1000, 1'b0);
        // R5 R6 R10: postincrement word load, slow memory
        run_op(1'b0, 1'b0, 3'd3, 3'd5, 16'h00F0, 32'h0000_2FF8, 1'b1);
        // R3 R4 R8: predecrement longword store, bit0=A7, bit15=D0
        run_op(1'b1, 1'b1, 3'd4, 3'd7, 16'h8001, 32'h0000_4000, 1'b0);
        // R1 R6 R8: ascending word store, all registers
        run_op(1'b1, 1'b0, 3'd5, 3'd0, 16'hFFFF, 32'h0000_5000, 1'b0);
        // R3 R4 R10: predecrement word store, slow memory
        run_op(1'b1, 1'b0, 3'd4, 3'd2, 16'h0F0F, 32'h0000_6100, 1'b1);
        // R9: empty masks
        run_op(1'b0, 1'b1, 3'd7, 3'd1, 16'h0000, 32'h0000_7000, 1'b0);
        run_op(1'b1, 1'b0, 3'd4, 3'd3, 16'h0000, 32'h0000_7100, 1'b0);
        // R7: mode 7 subfield 3 word load
        run_op(1'b0, 1'b0, 3'd7, 3'd3, 16'h0003, 32'h0000_8002, 1'b0);
        // R8: unlisted store subfield adds nothing
        run_op(1'b1, 1'b1, 3'd7, 3'd2, 16'h0420, 32'h0000_9000, 1'b1);
        // R7: mode 6 longword load, slow
        run_op(1'b0, 1'b1, 3'd6, 3'd0, 16'h1248, 32'h0000_A000, 1'b1);

        // R11: start during busy is ignored
        @(negedge clk);
        dir_store = 1'b0; size_long = 1'b1; ea_mode = 3'd2; reg_mask = 16'h0001;
        base_addr = 32'h0000_B000; start = 1'b1;
        @(negedge clk);
        reg_mask = 16'h0002; base_addr = 32'h0000_C000;
        @(negedge clk);
        start = 1'b0;
        mem_ready = 1'b0;
        chk(mem_req === 1'b1 && mem_addr === 32'h0000_B000, "R11 start ignored while busy",
            mem_addr, 32'h0000_B000);
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        chk(done === 1'b1 && mem_req === 1'b0, "R11 single transfer then done",
            {30'd0, done, mem_req}, 32'd2);
        @(negedge clk);
        chk(busy === 1'b0, "R11 idle after done", {31'd0, busy}, 32'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule